// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block runs the external bus of a small 8-bit processor whose lower address byte and data share one set of lines. A start pulse carries a cycle kind, a 16-bit address and, for writes, a data byte. The block then steps through its T-states. In the first state it raises the address-latch strobe and presents the full address: the high byte on dedicated lines and the low byte on the shared lines. In the middle states it runs the read or write strobe. After the last state it reports completion and returns any byte it read.

The memory or I/O side can stretch a transfer by pulling ready low. Another bus master can take the bus by raising a hold request. The block first finishes the cycle in flight. It then acknowledges the hold and releases every bus driver until the request drops.

All bus outputs are registered. Each one changes on the same clock edge as the internal T-state register.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, ale is 0, rd_n and wr_n are 1, ad_oe is 0, hlda is 0, bus_oe is 1, and busy and done are 0.
- R2: ale is high in the first T-state after an accepted start and only then. In that state addr_hi carries address bits 15:8, ad_out carries bits 7:0, and ad_oe is 1.
- R3: An opcode fetch occupies four T-states and every other kind occupies three, plus any wait states. done is high for exactly one cycle directly after the last T-state, and busy is high during every T-state.
- R4: kind codes: 000 opcode fetch (s1,s0 = 1,1), 001 memory read (1,0), 010 memory write (0,1), 011 I/O read (1,0), 100 I/O write (0,1). io_m is 1 for the I/O kinds and 0 for the memory kinds. Both encodings hold for all T-states of the cycle.
- R5: For fetch and read kinds, rd_n is 0 in the second T-state and in any wait states, and 1 otherwise. wr_n stays 1 and ad_oe is 0 outside the first state. rdata takes the byte on ad_in at the edge that leaves the strobe phase.
- R6: For write kinds, wr_n is 0 in the second T-state and in any wait states, and rd_n stays 1. From the second state through the third, ad_out carries the write byte with ad_oe 1.
- R7: The fourth state of an opcode fetch has both strobes at 1, ad_oe at 0 and ale at 0.
- R8: ready is sampled at the end of the second T-state and of each wait state. Each low sample adds one wait state, in which the strobe stays active and the address stays stable.
- R9: A hold request raised during a cycle lets that cycle finish. hlda rises together with done. While hlda is 1, bus_oe and ad_oe are 0 and both strobes are 1. hlda falls, and bus_oe returns to 1, one cycle after hold drops.
- R10: When start and hold meet in an idle cycle, hold wins and the start is discarded. A start given while hlda is 1 is also discarded.
- R11: A start is ignored while busy is 1, and a start with kind 101, 110 or 111 is ignored; no ale follows either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a machine cycle |
| kind | input | 3 | Cycle kind code |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | A machine cycle is in progress |
| done | output | 1 | One-cycle pulse after the last T-state |
| rdata | output | 8 | Byte captured by the last read or fetch |
| ale | output | 1 | Address-latch strobe |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Shared address/data lines, incoming value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready | input | 1 | Low to stretch the transfer |
| hold | input | 1 | Bus handover request |
| hlda | output | 1 | Hold acknowledge |
| bus_oe | output | 1 | Drive enable for address and control outputs |

## Verification
A start pulse and a hold request can fall in the same idle cycle. The arbitration between them decides whether a new ale appears or the bus is given up. The bench raises both together and checks that hlda rises with no ale, and that no cycle begins after hold is dropped. It also raises hold in the middle of a cycle, sometimes during wait states. It then checks that the cycle still ends with its normal strobes and done pulse, with hlda rising in that same cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int KIND_W = 3;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4, ST_HOLD
  } tstate_e;

  localparam logic [KIND_W-1:0] K_FETCH = 3'd0;
  localparam logic [KIND_W-1:0] K_MRD   = 3'd1;
  localparam logic [KIND_W-1:0] K_MWR   = 3'd2;
  localparam logic [KIND_W-1:0] K_IORD  = 3'd3;
  localparam logic [KIND_W-1:0] K_IOWR  = 3'd4;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } cyc_t;

  function automatic logic kind_ok(input logic [KIND_W-1:0] k);
    return k <= K_IOWR;
  endfunction

  function automatic logic kind_rd(input logic [KIND_W-1:0] k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_wr(input logic [KIND_W-1:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_io(input logic [KIND_W-1:0] k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  // {s1, s0}
  function automatic logic [1:0] kind_stat(input logic [KIND_W-1:0] k);
    if (k == K_FETCH) return 2'b11;
    if (kind_rd(k))   return 2'b10;
    return 2'b01;
  endfunction
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [KIND_W-1:0] kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  input  logic              hold,
  output tstate_e           st_nxt,
  output cyc_t              cyc_nxt,
  output logic              capture,
  output logic              fin
);
  tstate_e st_q;
  cyc_t    cyc_q;
  logic    accept;
  logic    is_fetch;

  assign accept   = (st_q == ST_IDLE) && start && !hold && kind_ok(kind);
  assign is_fetch = (cyc_q.kind == K_FETCH);
  assign capture  = ((st_q == ST_T2) || (st_q == ST_TW)) && ready && kind_rd(cyc_q.kind);
  assign fin      = ((st_q == ST_T3) && !is_fetch) || (st_q == ST_T4);

  always_comb begin
    cyc_nxt = accept ? '{kind: kind, addr: addr, wdata: wdata} : cyc_q;
    st_nxt  = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold)        st_nxt = ST_HOLD;
        else if (accept) st_nxt = ST_T1;
      end
      ST_T1:   st_nxt = ST_T2;
      ST_T2,
      ST_TW:   st_nxt = ready ? ST_T3 : ST_TW;
      ST_T3: begin
        if (is_fetch)    st_nxt = ST_T4;
        else             st_nxt = hold ? ST_HOLD : ST_IDLE;
      end
      ST_T4:   st_nxt = hold ? ST_HOLD : ST_IDLE;
      ST_HOLD: st_nxt = hold ? ST_HOLD : ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cyc_q <= cyc_nxt;
    end
  end
endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  tstate_e           st_nxt,
  input  cyc_t              cyc_nxt,
  input  logic              capture,
  input  logic              fin,
  input  logic [DATA_W-1:0] ad_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic              hlda,
  output logic              bus_oe
);
  logic active, strobe_ph, wr_ph, is_rd, is_wr;

  assign active    = (st_nxt == ST_T1) || (st_nxt == ST_T2) || (st_nxt == ST_TW)
                  || (st_nxt == ST_T3) || (st_nxt == ST_T4);
  assign strobe_ph = (st_nxt == ST_T2) || (st_nxt == ST_TW);
  assign is_rd     = kind_rd(cyc_nxt.kind);
  assign is_wr     = kind_wr(cyc_nxt.kind);
  assign wr_ph     = is_wr && (strobe_ph || (st_nxt == ST_T3));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      ale     <= 1'b0;
      addr_hi <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      io_m    <= 1'b0;
      s1      <= 1'b0;
      s0      <= 1'b0;
      hlda    <= 1'b0;
      bus_oe  <= 1'b1;
    end else begin
      busy    <= active;
      done    <= fin;
      if (capture) rdata <= ad_in;
      ale     <= (st_nxt == ST_T1);
      addr_hi <= active ? cyc_nxt.addr[ADDR_W-1:DATA_W] : '0;
      if (st_nxt == ST_T1)  ad_out <= cyc_nxt.addr[DATA_W-1:0];
      else if (wr_ph)       ad_out <= cyc_nxt.wdata;
      else                  ad_out <= '0;
      ad_oe   <= (st_nxt == ST_T1) || wr_ph;
      rd_n    <= !(is_rd && strobe_ph);
      wr_n    <= !(is_wr && strobe_ph);
      io_m    <= active && kind_io(cyc_nxt.kind);
      {s1, s0} <= active ? kind_stat(cyc_nxt.kind) : 2'b00;
      hlda    <= (st_nxt == ST_HOLD);
      bus_oe  <= (st_nxt != ST_HOLD);
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [KIND_W-1:0] kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda,
  output logic              bus_oe
);
  tstate_e st_nxt;
  cyc_t    cyc_nxt;
  logic    capture, fin;

  bcs_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .addr(addr),
    .wdata(wdata), .ready(ready), .hold(hold), .st_nxt(st_nxt),
    .cyc_nxt(cyc_nxt), .capture(capture), .fin(fin)
  );

  bcs_drive u_drive (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .cyc_nxt(cyc_nxt),
    .capture(capture), .fin(fin), .ad_in(ad_in), .busy(busy), .done(done),
    .rdata(rdata), .ale(ale), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
    .hlda(hlda), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic       ready,
  input logic       hlda,
  input logic       bus_oe,
  input logic       busy,
  input logic [7:0] addr_hi
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (rd_n && wr_n && !ale && !hlda && !busy && bus_oe));

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R8
  rd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !ready) |=> (!rd_n && $stable(addr_hi)));

  // R8
  wr_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !ready) |=> (!wr_n && $stable(addr_hi)));

  // R9
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!bus_oe && !ad_oe && rd_n && wr_n && !busy));

  // R10
  hold_no_ale_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |=> !ale);
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .ready(ready), .hlda(hlda), .bus_oe(bus_oe), .busy(busy), .addr_hi(addr_hi)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start, ready, hold;
  logic [2:0]  kind;
  logic [15:0] addr;
  logic [7:0]  wdata, ad_in;
  logic        busy, done, ale, ad_oe, rd_n, wr_n, io_m, s1, s0, hlda, bus_oe;
  logic [7:0]  rdata, addr_hi, ad_out;

  bus_cycle_seq uut (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .ale(ale), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0), .ready(ready), .hold(hold), .hlda(hlda),
    .bus_oe(bus_oe)
  );

  // Device model: 256 bytes indexed by high ^ low address byte
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0] lat_lo;
  always @(negedge clk) if (ale) lat_lo <= ad_out;
  always @(negedge clk) if (!wr_n) mem[addr_hi ^ lat_lo] <= ad_out;
  assign ad_in = (!rd_n) ? mem[addr_hi ^ lat_lo] : 8'h00;

  int nchk = 0, nerr = 0;
  bit ended = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  function automatic bit f_rd(input logic [2:0] k); return k == 0 || k == 1 || k == 3; endfunction
  function automatic bit f_wr(input logic [2:0] k); return k == 2 || k == 4; endfunction
  function automatic logic [1:0] f_st(input logic [2:0] k);
    return (k == 0) ? 2'b11 : f_rd(k) ? 2'b10 : 2'b01;
  endfunction

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d,
                           input int nwait, input bit hold_mid, input bit poke);
    bit rdk = f_rd(k);
    bit wrk = f_wr(k);
    logic [7:0] idx = a[15:8] ^ a[7:0];
    @(negedge clk);
    start = 1; kind = k; addr = a; wdata = d; ready = (nwait == 0);
    @(negedge clk);  // T1
    start = 0;
    chk("R2 ale", ale, 1);
    chk("R2 addr_hi", addr_hi, a[15:8]);
    chk("R2 ad_out", ad_out, a[7:0]);
    chk("R2 ad_oe", ad_oe, 1);
    chk("R4 status", {s1, s0}, f_st(k));
    chk("R4 io_m", io_m, (k == 3 || k == 4));
    chk("R3 busy", busy, 1);
    @(negedge clk);  // T2
    if (poke) begin start = 1; kind = 3'd1; addr = ~a; end
    if (hold_mid) hold = 1;
    chk("R5 rd_n T2", rd_n, !rdk);
    chk("R6 wr_n T2", wr_n, !wrk);
    chk("R5 ad_oe T2", ad_oe, wrk);
    if (wrk) chk("R6 ad_out T2", ad_out, d);
    chk("R2 ale T2", ale, 0);
    for (int w = 0; w < nwait; w++) begin
      @(negedge clk);  // wait state
      start = 0;
      chk("R8 rd_n wait", rd_n, !rdk);
      chk("R8 wr_n wait", wr_n, !wrk);
      chk("R8 addr_hi wait", addr_hi, a[15:8]);
      chk("R11 no ale", ale, 0);
      ready = (w + 1 == nwait);
    end
    @(negedge clk);  // T3
    start = 0;
    chk("R5 rd_n T3", rd_n, 1);
    chk("R6 wr_n T3", wr_n, 1);
    chk("R11 ale T3", ale, 0);
    chk("R11 addr_hi T3", addr_hi, a[15:8]);
    chk("R3 done T3", done, 0);
    if (wrk) chk("R6 ad_out T3", ad_out, d);
    if (rdk) chk("R5 rdata", rdata, shadow[idx]);
    if (k == 0) begin
      @(negedge clk);  // T4
      chk("R7 rd_n", rd_n, 1);
      chk("R7 ad_oe", ad_oe, 0);
      chk("R7 ale", ale, 0);
      chk("R4 status T4", {s1, s0}, 2'b11);
      chk("R3 busy T4", busy, 1);
    end
    @(negedge clk);  // after last state
    chk("R3 done", done, 1);
    chk("R3 busy end", busy, 0);
    chk("R9 hlda end", hlda, hold_mid);
    if (hold_mid) chk("R9 bus_oe", bus_oe, 0);
    ready = 1;
    if (wrk) shadow[idx] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    rst = 1; start = 0; ready = 1; hold = 0; kind = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n}, 2'b11);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 hlda/bus_oe", {hlda, bus_oe}, 2'b01);
    chk("R1 busy/done", {busy, done}, 2'b00);
    rst = 0;

    // each kind, no waits, then with waits
    run_cycle(3'd0, 16'h1234, 8'h00, 0, 0, 0);
    run_cycle(3'd2, 16'h00A5, 8'h5C, 0, 0, 0);
    run_cycle(3'd1, 16'h00A5, 8'h00, 0, 0, 0);   // reads back the write
    run_cycle(3'd3, 16'hFF10, 8'h00, 1, 0, 0);
    run_cycle(3'd4, 16'h8001, 8'hE7, 3, 0, 1);
    run_cycle(3'd0, 16'h8001, 8'h00, 2, 0, 1);

    // R9: hold during a cycle with waits
    run_cycle(3'd1, 16'h4242, 8'h00, 2, 1, 0);
    // R10: start while hlda
    @(negedge clk); start = 1; kind = 3'd0; addr = 16'h7777;
    @(negedge clk); start = 0;
    chk("R10 ale in hold", ale, 0);
    chk("R10 hlda kept", hlda, 1);
    chk("R9 ad_oe in hold", ad_oe, 0);
    hold = 0;
    @(negedge clk);
    chk("R9 hlda drop", hlda, 0);
    chk("R9 bus_oe back", bus_oe, 1);
    @(negedge clk);
    chk("R10 no late ale", ale, 0);

    // R10: start and hold meet in idle
    @(negedge clk); start = 1; hold = 1; kind = 3'd2; addr = 16'h0101;
    @(negedge clk); start = 0;
    chk("R10 hold wins hlda", hlda, 1);
    chk("R10 hold wins ale", ale, 0);
    hold = 0;
    @(negedge clk);
    chk("R10 released", hlda, 0);
    @(negedge clk);
    chk("R10 start dropped", {ale, busy}, 2'b00);

    // R11: invalid kinds
    for (int k = 5; k < 8; k++) begin
      @(negedge clk); start = 1; kind = 3'(k); addr = 16'hABCD;
      @(negedge clk); start = 0;
      chk("R11 bad kind ale", ale, 0);
      chk("R11 bad kind busy", busy, 0);
    end

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic [2:0] rk = 3'($urandom_range(0, 4));
      run_cycle(rk, 16'($urandom), 8'($urandom), $urandom_range(0, 3), 0,
                1'($urandom_range(0, 1)));
    end
    run_cycle(3'd4, 16'h3C3C, 8'h99, 0, 1, 0);
    hold = 0;
    @(negedge clk);
    chk("R9 final release", {hlda, bus_oe}, 2'b01);
    finish_run();
  end
endmodule